// File: doc/BRIEF.md
# MII Receive Nibble-to-Byte Assembler

This block takes the four-bit receive side of a media-independent interface and turns each incoming frame into a byte stream. It runs entirely on the receive clock from the transceiver. It works the same at 2.5 MHz (10 Mbps line) and at 25 MHz (100 Mbps line), because it never counts clock periods and only responds to sampled edges. Preamble nibbles are discarded. The start-of-frame delimiter is found as nibble 0x5 followed directly by nibble 0xD. Each later pair of nibbles becomes one byte, with the first nibble in the low half.

Each output byte comes with a valid strobe. The first byte of a frame carries a start marker. The last byte carries an end marker and two status bits in the same cycle. One status bit reports a coding error seen at any edge while the data-valid line was high. The other reports that the frame ended with an unpaired nibble. To know which byte is the last one, the block holds each completed byte until the next byte completes or until data-valid falls. A downstream CRC checker or frame buffer attaches directly to the output.

Top module: `mii_rx_nibble_asm`

## Requirements
- R1: While `rst` is high, and in the first cycle after a clock edge that sampled `rst` high, `out_valid`, `out_sof`, `out_eof`, `out_err` and `out_align` are all 0.
- R2: `rxd` and `rx_er` are sampled only at rising edges where `rx_dv` is 1. At an edge with `rx_dv` low, nibble values (including 0x5 then 0xD) and `rx_er` produce no output byte and do not change the status of any frame. A byte that is not an end-of-frame byte is only emitted after an edge that sampled `rx_dv` high.
- R3: Nibbles before the delimiter are dropped. The delimiter is the nibble 0x5 at one valid edge followed by 0xD at the next valid edge. A 0xD that follows any nibble other than 0x5 is not a delimiter.
- R4: After the delimiter, nibbles pair in arrival order. Each output byte equals {second nibble, first nibble}, so bits [3:0] hold the earlier nibble.
- R5: `out_sof` is 1 on the first emitted byte of each frame and on no other byte.
- R6: `out_eof` is 1 together with the last byte of the frame, in one cycle. It follows the clock edge at which `rx_dv` is first sampled low after the frame. Output byte order matches input order.
- R7: If `rx_er` is 1 at any edge with `rx_dv` high in a frame (preamble included), `out_err` is 1 on that frame's end byte. Otherwise it is 0.
- R8: If `rx_dv` falls with an unpaired nibble, the nibble is dropped and `out_align` is 1 on the end byte. Otherwise it is 0.
- R9: A frame in which `rx_dv` falls before a delimiter is found, or before one byte completes, emits no byte.
- R10: `out_sof` and `out_eof` are only 1 when `out_valid` is 1. `out_err` and `out_align` are only 1 when `out_eof` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the transceiver, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive coding error, qualified by `rx_dv` |
| rxd | input | 4 | Receive nibble |
| out_valid | output | 1 | An assembled byte is present |
| out_data | output | 8 | Assembled byte, earlier nibble in bits [3:0] |
| out_sof | output | 1 | First byte of the frame |
| out_eof | output | 1 | Last byte of the frame |
| out_err | output | 1 | Frame saw a coding error; valid with `out_eof` |
| out_align | output | 1 | Frame ended on an odd nibble; valid with `out_eof` |

## Verification
The bench targets delimiter recognition. It sends a 0xD preceded by a non-0x5 nibble, and a delimiter pattern driven while `rx_dv` is low. A design that accepted either case would emit bytes that were never framed. It checks that the nibble order is visible in the bytes and that the end marker sits on the true last byte, including in a one-byte frame where start and end coincide. A design that marked the end a cycle late would show the marker on an empty cycle or lose a byte. It also checks error handling. An error raised in the preamble must taint the frame, and an error raised while `rx_dv` is low must not leak into the next frame. Frames with an odd trailing nibble must flag misalignment, and frames that end before the delimiter must stay silent.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int NIB_W_DEF = 4;

  typedef enum logic [0:0] {
    ST_HUNT = 1'b0,
    ST_DATA = 1'b1
  } rx_state_e;
endpackage

// File: rtl/mii_rx_sfd_hunt.sv
// Frame-state tracker: discards preamble, finds the delimiter, and reports
// the end of a framed window.
module mii_rx_sfd_hunt
  import mii_rx_pkg::*;
#(
  parameter int               NIB_W   = NIB_W_DEF,
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dv,
  input  logic [NIB_W-1:0] nib,
  output logic             in_data,
  output logic             sfd_hit,
  output logic             frame_end
);
  rx_state_e state_q;
  logic      prev_pre_q;

  assign in_data   = (state_q == ST_DATA);
  assign sfd_hit   = (state_q == ST_HUNT) && dv && prev_pre_q && (nib == SFD_NIB);
  assign frame_end = (state_q == ST_DATA) && !dv;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_HUNT;
      prev_pre_q <= 1'b0;
    end else begin
      case (state_q)
        ST_HUNT: begin
          prev_pre_q <= dv && (nib == PRE_NIB);
          if (sfd_hit) state_q <= ST_DATA;
        end
        default: begin
          prev_pre_q <= 1'b0;
          if (!dv) state_q <= ST_HUNT;
        end
      endcase
    end
  end
endmodule

// File: rtl/mii_rx_nib_pair.sv
// Pairs nibbles into bytes, earlier nibble in the low half.
module mii_rx_nib_pair #(
  parameter int NIB_W  = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              clear,
  input  logic [NIB_W-1:0]  nib,
  output logic              half,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  logic [NIB_W-1:0] low_q;
  logic             half_q;

  assign half      = half_q;
  assign byte_done = take && half_q;
  assign byte_val  = {nib, low_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      low_q  <= '0;
    end else if (clear) begin
      half_q <= 1'b0;
    end else if (take) begin
      if (!half_q) low_q <= nib;
      half_q <= !half_q;
    end
  end
endmodule

// File: rtl/mii_rx_nibble_asm.sv
module mii_rx_nibble_asm
  import mii_rx_pkg::*;
#(
  parameter int  NIB_W  = NIB_W_DEF,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_dv,
  input  logic              rx_er,
  input  logic [NIB_W-1:0]  rxd,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_err,
  output logic              out_align
);
  logic              in_data, sfd_hit, frame_end;
  logic              half, byte_done;
  logic [BYTE_W-1:0] byte_val;

  logic [BYTE_W-1:0] held_q;
  logic              held_v_q;
  logic              first_q;
  logic              err_acc_q;

  mii_rx_sfd_hunt #(.NIB_W(NIB_W)) hunt_i (
    .clk       (clk),
    .rst       (rst),
    .dv        (rx_dv),
    .nib       (rxd),
    .in_data   (in_data),
    .sfd_hit   (sfd_hit),
    .frame_end (frame_end)
  );

  mii_rx_nib_pair #(.NIB_W(NIB_W)) pair_i (
    .clk       (clk),
    .rst       (rst),
    .take      (in_data && rx_dv),
    .clear     (frame_end),
    .nib       (rxd),
    .half      (half),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_err   <= 1'b0;
      out_align <= 1'b0;
      held_q    <= '0;
      held_v_q  <= 1'b0;
      first_q   <= 1'b0;
      err_acc_q <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_err   <= 1'b0;
      out_align <= 1'b0;

      if (!rx_dv)     err_acc_q <= 1'b0;
      else if (rx_er) err_acc_q <= 1'b1;

      if (sfd_hit) begin
        first_q  <= 1'b1;
        held_v_q <= 1'b0;
      end

      if (byte_done) begin
        held_q   <= byte_val;
        held_v_q <= 1'b1;
        if (held_v_q) begin
          out_valid <= 1'b1;
          out_data  <= held_q;
          out_sof   <= first_q;
          first_q   <= 1'b0;
        end
      end

      if (frame_end) begin
        held_v_q <= 1'b0;
        first_q  <= 1'b0;
        if (held_v_q) begin
          out_valid <= 1'b1;
          out_data  <= held_q;
          out_sof   <= first_q;
          out_eof   <= 1'b1;
          out_err   <= err_acc_q;
          out_align <= half;
        end
      end
    end
  end
endmodule

// File: rtl/mii_rx_nibble_asm_chk.sv
module mii_rx_nibble_asm_chk (
  input logic clk,
  input logic rst,
  input logic rx_dv,
  input logic out_valid,
  input logic out_sof,
  input logic out_eof,
  input logic out_err,
  input logic out_align
);
  logic in_frame_q;

  always_ff @(posedge clk) begin
    if (rst)            in_frame_q <= 1'b0;
    else if (out_valid) in_frame_q <= !out_eof;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !out_valid && !out_sof && !out_eof && !out_err && !out_align);

  // R5
  sof_once_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sof |-> !in_frame_q);

  // R5
  byte_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_sof |-> in_frame_q);

  // R10
  marker_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_sof || out_eof) |-> out_valid);

  // R10
  status_on_eof_chk: assert property (@(posedge clk) disable iff (rst)
    (out_err || out_align) |-> out_eof);

  // R6
  eof_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> !$past(rx_dv));

  // R2
  mid_byte_needs_dv_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_eof |-> $past(rx_dv));
endmodule

bind mii_rx_nibble_asm mii_rx_nibble_asm_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .rx_dv     (rx_dv),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_eof   (out_eof),
  .out_err   (out_err),
  .out_align (out_align)
);

// File: tb/mii_rx_nibble_asm_tb_top.sv
`timescale 1ns/1ps
module mii_rx_nibble_asm_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_dv = 1'b0;
  logic       rx_er = 1'b0;
  logic [3:0] rxd = 4'h0;
  logic       out_valid, out_sof, out_eof, out_err, out_align;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;

  logic [3:0] nibs [0:127];
  logic       ers  [0:127];
  int         nn;
  logic [7:0] exp_b [0:63];
  int         exp_n;

  logic [7:0] cap_d [0:63];
  logic       cap_s [0:63];
  logic       cap_e [0:63];
  logic       cap_r [0:63];
  logic       cap_a [0:63];
  int         cap_n;

  always #2 clk = ~clk;

  mii_rx_nibble_asm dut_i (
    .clk(clk), .rst(rst), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_err(out_err), .out_align(out_align)
  );

  always @(negedge clk) begin
    if (!rst && out_valid && cap_n < 64) begin
      cap_d[cap_n] = out_data;
      cap_s[cap_n] = out_sof;
      cap_e[cap_n] = out_eof;
      cap_r[cap_n] = out_err;
      cap_a[cap_n] = out_align;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_frame();
    nn = 0; exp_n = 0; cap_n = 0;
  endtask

  task automatic add_nib(input logic [3:0] n, input logic e);
    nibs[nn] = n; ers[nn] = e; nn++;
  endtask

  task automatic add_pre_sfd(input int pre_len);
    for (int i = 0; i < pre_len; i++) add_nib(4'h5, 1'b0);
    add_nib(4'hD, 1'b0);
  endtask

  task automatic add_byte(input logic [7:0] b);
    add_nib(b[3:0], 1'b0);
    add_nib(b[7:4], 1'b0);
    exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic play();
    for (int i = 0; i < nn; i++) begin
      @(negedge clk); rx_dv = 1'b1; rxd = nibs[i]; rx_er = ers[i];
    end
    @(negedge clk); rx_dv = 1'b0; rx_er = 1'b0; rxd = 4'h0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input bit e_err, input bit e_al);
    chk(cap_n == exp_n, req, "byte count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_d[i] == exp_b[i], req, "byte value", cap_d[i], exp_b[i]);
      chk(cap_s[i] == (i == 0), "R5", "sof marker", cap_s[i], i == 0);
      chk(cap_e[i] == (i == exp_n - 1), "R6", "eof marker", cap_e[i], i == exp_n - 1);
      chk(cap_r[i] == ((i == exp_n - 1) && e_err), "R7", "err status",
          cap_r[i], (i == exp_n - 1) && e_err);
      chk(cap_a[i] == ((i == exp_n - 1) && e_al), "R8", "align status",
          cap_a[i], (i == exp_n - 1) && e_al);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_sof && !out_eof && !out_err && !out_align, "R1",
        "outputs in reset", {out_valid, out_sof, out_eof, out_err, out_align}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R1", "valid after reset", out_valid, 0);
  endtask

  task automatic t_basic();
    clear_frame();
    add_pre_sfd(15);
    add_byte(8'h12); add_byte(8'hAB); add_byte(8'hFF);
    add_byte(8'h00); add_byte(8'h5D);
    play();
    check_frame("R4", 1'b0, 1'b0);
  endtask

  task automatic t_err_data();
    clear_frame();
    add_pre_sfd(7);
    add_byte(8'hC3); add_byte(8'h81);
    ers[nn-1] = 1'b1;
    add_byte(8'h7E);
    play();
    check_frame("R7", 1'b1, 1'b0);
  endtask

  task automatic t_err_preamble();
    clear_frame();
    add_pre_sfd(6);
    ers[2] = 1'b1;
    add_byte(8'h44); add_byte(8'h99);
    play();
    check_frame("R7", 1'b1, 1'b0);
  endtask

  task automatic t_ignore_idle();
    cap_n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); rx_dv = 1'b0; rx_er = 1'b1;
      rxd = (i % 2 == 0) ? 4'h5 : 4'hD;
    end
    @(negedge clk); rx_er = 1'b0; rxd = 4'h0;
    repeat (3) @(negedge clk);
    chk(cap_n == 0, "R2", "output while dv low", cap_n, 0);
    clear_frame();
    add_byte(8'h21); add_byte(8'h43);
    play();
    chk(cap_n == 0, "R2", "bytes without delimiter", cap_n, 0);
    clear_frame();
    add_pre_sfd(3);
    add_byte(8'h6A); add_byte(8'hB7);
    play();
    check_frame("R2", 1'b0, 1'b0);
  endtask

  task automatic t_odd();
    clear_frame();
    add_pre_sfd(9);
    add_byte(8'h34); add_byte(8'h56);
    add_nib(4'h7, 1'b0);
    play();
    check_frame("R8", 1'b0, 1'b1);
  endtask

  task automatic t_no_sfd();
    clear_frame();
    for (int i = 0; i < 10; i++) add_nib(4'h5, 1'b0);
    play();
    chk(cap_n == 0, "R9", "bytes from preamble only", cap_n, 0);
    clear_frame();
    add_pre_sfd(4);
    add_nib(4'h9, 1'b0);
    play();
    chk(cap_n == 0, "R9", "bytes from lone nibble", cap_n, 0);
  endtask

  task automatic t_single();
    clear_frame();
    add_pre_sfd(2);
    add_byte(8'hE1);
    play();
    chk(cap_n == 1 && cap_s[0] && cap_e[0], "R6", "single byte sof and eof",
        {cap_s[0], cap_e[0]}, 2'b11);
    check_frame("R6", 1'b0, 1'b0);
  endtask

  task automatic t_false_sfd();
    clear_frame();
    add_nib(4'h5, 1'b0); add_nib(4'h5, 1'b0);
    add_nib(4'hA, 1'b0); add_nib(4'hD, 1'b0);
    add_nib(4'hC, 1'b0); add_nib(4'h3, 1'b0);
    add_nib(4'h5, 1'b0); add_nib(4'hD, 1'b0);
    add_byte(8'h9E); add_byte(8'h0F);
    play();
    check_frame("R3", 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    clear_frame();
    add_pre_sfd(5);
    add_byte(8'h11); add_byte(8'h22);
    for (int i = 0; i < nn; i++) begin
      @(negedge clk); rx_dv = 1'b1; rxd = nibs[i]; rx_er = 1'b0;
    end
    @(negedge clk); rx_dv = 1'b0;
    nn = 0; exp_n = 0;
    add_pre_sfd(3);
    add_byte(8'h33); add_byte(8'h44); add_byte(8'h55);
    exp_b[0] = 8'h11; exp_b[1] = 8'h22; exp_b[2] = 8'h33;
    exp_b[3] = 8'h44; exp_b[4] = 8'h55;
    play();
    chk(cap_n == 5, "R5", "two frames byte count", cap_n, 5);
    if (cap_n == 5) begin
      chk(cap_s[0] && cap_e[1] && cap_s[2] && cap_e[4] && !cap_s[1] && !cap_e[2],
          "R5", "markers across frames",
          {cap_s[0], cap_e[1], cap_s[2], cap_e[4]}, 4'hF);
      for (int i = 0; i < 5; i++)
        chk(cap_d[i] == exp_b[i], "R6", "order across frames", cap_d[i], exp_b[i]);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cap_n = 0; nn = 0; exp_n = 0;
    t_reset();
    t_basic();
    t_err_data();
    t_ignore_idle();
    t_err_preamble();
    t_odd();
    t_no_sfd();
    t_single();
    t_false_sfd();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule